// File: doc/BRIEF.md
# Mailbox Command Block Sequencer

This block sits on the local side of a host mailbox register. The host writes one word per mailbox write. The first word of each block is a command word. Its one-hot command bits select what the block is and fix how many parameter words follow it. The sequencer counts the parameter words as they arrive and stores them in arrival order. Once the last one is in, it presents the whole block for one cycle: the decoded command kind, the parameter count and the parameter array.

A ready output tells the writer when a word can be accepted. Ready drops only for the single cycle in which a block is presented. A command that asks for notification raises an interrupt pulse in that same cycle. A command word with no recognised command bit, or with more than one, is rejected with an error pulse, and the sequencer keeps waiting for a command word. Executing the commands (loading, dumping, starting code) is left to the consumer of the presented block.

Top module: `mbx_cmd_seq`

## Requirements
- R1: After reset, rdy is 1 and blkValid, irqDone and cmdErr are 0. cmdKind, paramCnt and every parameter slot read 0.
- R2: The command bits are word bits 0, 5, 7, 9, 11, 13 and 15. A command word is valid when exactly one of them is set, and all other bits of the word are ignored. The kind codes and parameter counts are:
  - bit 5: kind 1, 0 parameters (last)
  - bit 7: kind 2, 2 parameters (shared-memory address)
  - bit 9: kind 3, 2 parameters (begin)
  - bit 11: kind 4, 1 parameter (notify on completion)
  - bit 13: kind 5, 5 parameters (dump)
  - bit 15: kind 6, 5 parameters (load)
  - bit 0: kind 7, 5 parameters (general I/O)
- R3: After a valid command word that takes N>0 parameters, the sequencer accepts exactly N further words. blkValid rises in the cycle after the clock edge that accepts the Nth word, and stays low before that.
- R4: Parameter words appear in arrival order, the first in slot 0, and paramCnt equals N. Slots at N and above read 0.
- R5: A command that takes 0 parameters gives blkValid in the cycle after its command word is accepted.
- R6: A command word with zero or several command bits set gives cmdErr high for exactly one cycle, in the cycle after it is accepted. It presents no block, and rdy stays 1.
- R7: blkValid lasts exactly one cycle, and rdy is 0 only during that cycle. A write offered while rdy is 0 is ignored.
- R8: irqDone is 1 only in the blkValid cycle of a kind-4 block.
- R9: cmdKind, paramCnt and the parameter slots hold their values after the block is presented, and through rejected command words, until the next valid command word is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Mailbox write strobe, one word per cycle |
| wrData | input | WORD_W | Mailbox word |
| rdy | output | 1 | A word offered now will be accepted |
| blkValid | output | 1 | Complete block presented this cycle |
| cmdKind | output | 3 | Decoded command kind (R2 codes) |
| paramCnt | output | CNT_W | Number of parameter words in the block |
| paramsFlat | output | MAX_PARAMS*WORD_W | Parameter slots, slot i at bits i*WORD_W upward |
| irqDone | output | 1 | Completion interrupt pulse |
| cmdErr | output | 1 | Rejected command word pulse |

## Verification
The bench builds the block with WORD_W=16 and MAX_PARAMS=6, one slot more than the longest block. That spare slot shows that the top slot stays zero even after five-word blocks. Every kind is sent with distinct parameter values, so a count that is off by one, or a slot that shifts, shows up at the ports. A short block is sent after a long one to expose stale slots, and a word is offered during the presentation cycle to show it is dropped.

// File: rtl/mbx_seq_pkg.sv
package mbx_seq_pkg;

  typedef enum logic [2:0] {
    K_NONE   = 3'd0,
    K_LAST   = 3'd1,
    K_SHMEM  = 3'd2,
    K_BEGIN  = 3'd3,
    K_NOTIFY = 3'd4,
    K_DUMP   = 3'd5,
    K_LOAD   = 3'd6,
    K_IO     = 3'd7
  } cmd_kind_e;

  localparam int LEN_W = 3;

  // Bit positions of command selectors inside the leading word
  localparam int BIT_IO     = 0;
  localparam int BIT_LAST   = 5;
  localparam int BIT_SHMEM  = 7;
  localparam int BIT_BEGIN  = 9;
  localparam int BIT_NOTIFY = 11;
  localparam int BIT_DUMP   = 13;
  localparam int BIT_LOAD   = 15;

  // Parameter word counts per kind
  localparam logic [LEN_W-1:0] N_LAST   = 3'd0;
  localparam logic [LEN_W-1:0] N_SHMEM  = 3'd2;
  localparam logic [LEN_W-1:0] N_BEGIN  = 3'd2;
  localparam logic [LEN_W-1:0] N_NOTIFY = 3'd1;
  localparam logic [LEN_W-1:0] N_DUMP   = 3'd5;
  localparam logic [LEN_W-1:0] N_LOAD   = 3'd5;
  localparam logic [LEN_W-1:0] N_IO     = 3'd5;
  localparam int LONGEST = 5;

  typedef struct packed {
    logic             ok;
    cmd_kind_e        kind;
    logic [LEN_W-1:0] len;
  } cmd_decode_t;

  typedef struct packed {
    logic loadCmd;
    logic loadParam;
  } dp_strobe_t;

  function automatic cmd_decode_t decodeCmd(input logic [15:0] w);
    cmd_decode_t d;
    logic [6:0]  sel;
    sel = {w[BIT_LOAD], w[BIT_DUMP], w[BIT_NOTIFY], w[BIT_BEGIN],
           w[BIT_SHMEM], w[BIT_LAST], w[BIT_IO]};
    d.ok   = $onehot(sel);
    d.kind = K_NONE;
    d.len  = '0;
    if (d.ok) begin
      case (1'b1)
        sel[0]:  begin d.kind = K_IO;     d.len = N_IO;     end
        sel[1]:  begin d.kind = K_LAST;   d.len = N_LAST;   end
        sel[2]:  begin d.kind = K_SHMEM;  d.len = N_SHMEM;  end
        sel[3]:  begin d.kind = K_BEGIN;  d.len = N_BEGIN;  end
        sel[4]:  begin d.kind = K_NOTIFY; d.len = N_NOTIFY; end
        sel[5]:  begin d.kind = K_DUMP;   d.len = N_DUMP;   end
        default: begin d.kind = K_LOAD;   d.len = N_LOAD;   end
      endcase
    end
    return d;
  endfunction

endpackage

// File: rtl/mbx_seq_ctrl.sv
module mbx_seq_ctrl
  import mbx_seq_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int MAX_PARAMS = 5,
  localparam int CNT_W     = $clog2(MAX_PARAMS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrData,
  output logic              rdy,
  output logic              blkValid,
  output logic              cmdErr,
  output dp_strobe_t        strobe,
  output cmd_decode_t       decoded
);

  typedef enum logic [1:0] {S_IDLE, S_COLLECT, S_DONE} seq_state_e;

  seq_state_e       state, stateNext;
  logic [CNT_W-1:0] remain, remainNext;
  logic             errQ, errNext;
  logic             accept;

  always_comb begin
    decoded = decodeCmd(wrData[15:0]);
    rdy     = (state != S_DONE);
    accept  = wrEn && rdy;
  end

  always_comb begin
    stateNext        = state;
    remainNext       = remain;
    errNext          = 1'b0;
    strobe.loadCmd   = 1'b0;
    strobe.loadParam = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (accept) begin
          if (!decoded.ok) begin
            errNext = 1'b1;
          end else begin
            strobe.loadCmd = 1'b1;
            remainNext     = CNT_W'(decoded.len);
            stateNext      = (decoded.len == '0) ? S_DONE : S_COLLECT;
          end
        end
      end
      S_COLLECT: begin
        if (accept) begin
          strobe.loadParam = 1'b1;
          remainNext       = remain - 1'b1;
          if (remain == CNT_W'(1)) stateNext = S_DONE;
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      remain <= '0;
      errQ   <= 1'b0;
    end else begin
      state  <= stateNext;
      remain <= remainNext;
      errQ   <= errNext;
    end
  end

  assign blkValid = (state == S_DONE);
  assign cmdErr   = errQ;

  a_r3_last_param_done: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_COLLECT && remain == CNT_W'(1) && accept) |=> blkValid);

  a_r5_empty_block_done: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && accept && decoded.ok && decoded.len == '0) |=> blkValid);

  a_r7_ready_returns: assert property (@(posedge clk) disable iff (!rstN)
    blkValid |=> (rdy && !blkValid));

  a_r6_error_no_block: assert property (@(posedge clk) disable iff (!rstN)
    cmdErr |-> (rdy && !blkValid));

  a_r3_remain_bound: assert property (@(posedge clk) disable iff (!rstN)
    remain <= CNT_W'(MAX_PARAMS));

endmodule

// File: rtl/mbx_seq_dpath.sv
module mbx_seq_dpath
  import mbx_seq_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int MAX_PARAMS = 5,
  localparam int CNT_W     = $clog2(MAX_PARAMS + 1)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [WORD_W-1:0]            wrData,
  input  dp_strobe_t                   strobe,
  input  cmd_decode_t                  decoded,
  input  logic                         showBlock,
  output logic [2:0]                   cmdKind,
  output logic [CNT_W-1:0]             paramCnt,
  output logic [MAX_PARAMS*WORD_W-1:0] paramsFlat,
  output logic                         irqDone
);

  cmd_kind_e        kindQ;
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] idxQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      kindQ <= K_NONE;
      cntQ  <= '0;
      idxQ  <= '0;
    end else if (strobe.loadCmd) begin
      kindQ <= decoded.kind;
      cntQ  <= CNT_W'(decoded.len);
      idxQ  <= '0;
    end else if (strobe.loadParam) begin
      idxQ  <= idxQ + 1'b1;
    end
  end

  for (genvar g = 0; g < MAX_PARAMS; g++) begin : g_slot
    logic [WORD_W-1:0] slotQ;
    always_ff @(posedge clk) begin
      if (!rstN || strobe.loadCmd) begin
        slotQ <= '0;
      end else if (strobe.loadParam && idxQ == CNT_W'(g)) begin
        slotQ <= wrData;
      end
    end
    assign paramsFlat[g*WORD_W +: WORD_W] = slotQ;
  end

  assign cmdKind  = kindQ;
  assign paramCnt = cntQ;
  assign irqDone  = showBlock && (kindQ == K_NOTIFY);

  a_r4_slot_in_range: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadParam |-> (idxQ < cntQ));

endmodule

// File: rtl/mbx_cmd_seq.sv
module mbx_cmd_seq
  import mbx_seq_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int MAX_PARAMS = 5,
  localparam int CNT_W     = $clog2(MAX_PARAMS + 1)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         wrEn,
  input  logic [WORD_W-1:0]            wrData,
  output logic                         rdy,
  output logic                         blkValid,
  output logic [2:0]                   cmdKind,
  output logic [CNT_W-1:0]             paramCnt,
  output logic [MAX_PARAMS*WORD_W-1:0] paramsFlat,
  output logic                         irqDone,
  output logic                         cmdErr
);

  initial begin
    if (WORD_W < 16)          $error("WORD_W must be at least 16");
    if (MAX_PARAMS < LONGEST) $error("MAX_PARAMS must hold the longest block");
  end

  dp_strobe_t  strobe;
  cmd_decode_t decoded;

  mbx_seq_ctrl #(.WORD_W(WORD_W), .MAX_PARAMS(MAX_PARAMS)) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .rdy(rdy), .blkValid(blkValid), .cmdErr(cmdErr),
    .strobe(strobe), .decoded(decoded)
  );

  mbx_seq_dpath #(.WORD_W(WORD_W), .MAX_PARAMS(MAX_PARAMS)) i_dpath (
    .clk(clk), .rstN(rstN), .wrData(wrData), .strobe(strobe),
    .decoded(decoded), .showBlock(blkValid), .cmdKind(cmdKind),
    .paramCnt(paramCnt), .paramsFlat(paramsFlat), .irqDone(irqDone)
  );

  a_r8_irq_within_block: assert property (@(posedge clk) disable iff (!rstN)
    irqDone |-> blkValid);

  a_r7_not_ready_only_presenting: assert property (@(posedge clk) disable iff (!rstN)
    !rdy |-> blkValid);

endmodule

// File: tb/test_mbx_cmd_seq.sv
module test_mbx_cmd_seq;
  localparam int CLK_PERIOD = 10;
  localparam int WORD_W     = 16;
  localparam int MAX_PARAMS = 6;
  localparam int CNT_W      = $clog2(MAX_PARAMS + 1);

  logic                         clk = 1'b0;
  logic                         rstN = 1'b0;
  logic                         wrEn = 1'b0;
  logic [WORD_W-1:0]            wrData = '0;
  logic                         rdy, blkValid, irqDone, cmdErr;
  logic [2:0]                   cmdKind;
  logic [CNT_W-1:0]             paramCnt;
  logic [MAX_PARAMS*WORD_W-1:0] paramsFlat;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbx_cmd_seq #(.WORD_W(WORD_W), .MAX_PARAMS(MAX_PARAMS)) i_mbx_cmd_seq (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdy(rdy),
    .blkValid(blkValid), .cmdKind(cmdKind), .paramCnt(paramCnt),
    .paramsFlat(paramsFlat), .irqDone(irqDone), .cmdErr(cmdErr)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [WORD_W-1:0] slot(input int i);
    return paramsFlat[i*WORD_W +: WORD_W];
  endfunction

  // Drive one word at a falling edge; return at the next falling edge,
  // after the rising edge that accepted it.
  task automatic put(input logic [WORD_W-1:0] w);
    @(negedge clk);
    wrEn = 1'b1; wrData = w;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1", "rdy", 32'(rdy), 1);
    chk("R1", "blkValid", 32'(blkValid), 0);
    chk("R1", "irqDone", 32'(irqDone), 0);
    chk("R1", "cmdErr", 32'(cmdErr), 0);
    chk("R1", "cmdKind", 32'(cmdKind), 0);
    chk("R1", "paramCnt", 32'(paramCnt), 0);
    chk("R1", "params", 32'(paramsFlat == '0), 1);
  endtask

  // Send a command word and n params valued base+i; check the block
  task automatic t_block(input logic [WORD_W-1:0] cmd, input int kind,
                         input int n, input logic [WORD_W-1:0] base);
    put(cmd);
    if (n == 0) begin
      chk("R5", "blkValid after empty cmd", 32'(blkValid), 1);
    end else begin
      chk("R3", "no block after cmd word", 32'(blkValid), 0);
      chk("R7", "rdy while collecting", 32'(rdy), 1);
      for (int i = 0; i < n; i++) begin
        put(base + WORD_W'(i));
        if (i < n - 1) chk("R3", "early blkValid", 32'(blkValid), 0);
      end
      chk("R3", "blkValid after last param", 32'(blkValid), 1);
    end
    chk("R7", "rdy low while presenting", 32'(rdy), 0);
    chk("R2", "cmdKind", 32'(cmdKind), 32'(kind));
    chk("R4", "paramCnt", 32'(paramCnt), 32'(n));
    for (int i = 0; i < MAX_PARAMS; i++)
      chk("R4", $sformatf("slot %0d", i), 32'(slot(i)),
          (i < n) ? 32'(base + WORD_W'(i)) : 32'd0);
    chk("R8", "irqDone", 32'(irqDone), (kind == 4) ? 1 : 0);
    idle(1);
    chk("R7", "blkValid one cycle", 32'(blkValid), 0);
    chk("R7", "rdy back", 32'(rdy), 1);
    chk("R8", "irq one cycle", 32'(irqDone), 0);
    chk("R9", "kind held", 32'(cmdKind), 32'(kind));
    chk("R9", "slot0 held", 32'(slot(0)), (n > 0) ? 32'(base) : 32'd0);
  endtask

  task automatic t_error(input logic [WORD_W-1:0] cmd, input int prevKind);
    put(cmd);
    chk("R6", "cmdErr pulse", 32'(cmdErr), 1);
    chk("R6", "no block", 32'(blkValid), 0);
    chk("R6", "rdy stays", 32'(rdy), 1);
    chk("R9", "kind kept on reject", 32'(cmdKind), 32'(prevKind));
    idle(1);
    chk("R6", "cmdErr one cycle", 32'(cmdErr), 0);
    chk("R6", "still no block", 32'(blkValid), 0);
  endtask

  task automatic t_write_while_busy();
    // Finish a notify block, then offer a word during the present cycle
    put(16'h0800);
    @(negedge clk);
    wrEn = 1'b1; wrData = 16'h7777;
    @(negedge clk);
    chk("R7", "present cycle reached", 32'(blkValid), 1);
    wrData = 16'h0020;            // offered while rdy is low
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
    chk("R7", "busy write dropped", 32'(blkValid), 0);
    chk("R7", "kind unchanged", 32'(cmdKind), 4);
    idle(1);
    chk("R7", "no late block", 32'(blkValid), 0);
    chk("R9", "param kept", 32'(slot(0)), 32'h7777);
  endtask

  initial begin
    idle(3);
    t_reset();
    @(negedge clk); rstN = 1'b1;
    t_reset();
    t_block(16'h8000, 6, 5, 16'hA100);  // load
    t_block(16'h0800, 4, 1, 16'hB200);  // notify
    t_block(16'h0020, 1, 0, 16'h0000);  // last
    t_block(16'h2000, 5, 5, 16'hC300);  // dump
    t_block(16'h0080, 2, 2, 16'hD400);  // shared-memory address, stale slot check
    t_block(16'h0200, 3, 2, 16'hE500);  // begin
    t_block(16'h0001, 7, 5, 16'hF600);  // general I/O
    t_error(16'h0000, 7);
    t_error(16'h8020, 7);
    t_error(16'h0042, 7);               // bits 1 and 6 are not command bits
    t_block(16'h0060, 1, 0, 16'h0000);  // extra non-command bit ignored (R2)
    t_write_while_busy();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule